// File: doc/BRIEF.md
# Fraction Lowest-Terms Reducer

This block takes an unsigned fraction, given as a numerator and a denominator of equal width, and returns the same value in lowest terms. It also returns the common factor that it removed. A single `start` strobe launches the work. The block then runs by itself and raises `done_o` for exactly one cycle when the results are valid.

The work is done in two phases and uses no multiplier or divider.

- **Common factor search.** The block applies the subtraction form of Euclid's method. In each cycle it compares the two working values three ways, and the larger one loses the smaller. When the two values are equal, that value is the greatest common divisor.
- **Division by counting.** Each original component is divided by the common factor. The block subtracts the factor repeatedly and counts the subtractions until nothing remains. The numerator is done first and the denominator second.

A zero numerator or a zero denominator cannot be handled by this method, because the search would never end. When either component is zero at start, the block does not iterate. It reports an error together with `done_o` on the next cycle and passes the operands through unchanged.

Top module: `frac_reduce`

## Requirements
- R1: While reset is held and right after it, `done_o` and `err_o` are low and `num_o`, `den_o` and `gcd_o` are zero.
- R2: For nonzero operands, `gcd_o` at completion equals the greatest common divisor of the two operands.
- R3: For nonzero operands, `num_o` equals numerator / gcd and `den_o` equals denominator / gcd at completion. For example, 3/12 gives 1/4.
- R4: If either operand is zero when a start is accepted, `done_o` and `err_o` are both high in the cycle after the start edge. In that case `num_o` and `den_o` equal the operands and `gcd_o` is 0. `err_o` is never high without `done_o`.
- R5: `done_o` is a pulse of exactly one cycle, and `err_o` stays low when the operands are nonzero.
- R6: A `start` that is asserted while a reduction is in progress is ignored. The running result and its timing are unaffected.
- R7: For nonzero operands, `done_o` is seen high after exactly s + n/g + d/g + 4 rising edges, counting the edge that accepts the start. Here s is the number of Euclid subtractions, n and d are the operands and g is their gcd.
- R8: While the block is idle and `start` is low, `num_o`, `den_o` and `gcd_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, accepted only when idle |
| num_i | input | W | Numerator operand |
| den_i | input | W | Denominator operand |
| num_o | output | W | Reduced numerator |
| den_o | output | W | Reduced denominator |
| gcd_o | output | W | Common factor removed (0 on error) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Zero-operand error, valid with `done_o` |

## Verification
The bench instantiates the block twice.

- **W = 16 (default).** This instance runs a table of directed fractions and a set of random operands of up to 10 bits. It covers coprime pairs, equal pairs, the all-ones pair 65535/65535 and a long counting run of 4096/1.
- **W = 8.** This instance brings the all-ones boundary of the datapath within reach. 255/1 drives the longest possible subtraction chain and the longest possible counting run in about five hundred cycles, and 255/255 exercises the shortest path at full scale.

// File: rtl/frac_pkg.sv
package frac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GCD,
        ST_CNUM,
        ST_CDEN,
        ST_DONE
    } frac_state_e;

endpackage

// File: rtl/frac_cmp3.sv
module frac_cmp3 #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         lt,
    output logic         eq,
    output logic         gt
);
    always_comb begin
        lt = (a < b);
        eq = (a == b);
        gt = (a > b);
    end
endmodule

// File: rtl/frac_euclid_step.sv
module frac_euclid_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         lt,
    input  logic         gt,
    output logic [W-1:0] a_nx,
    output logic [W-1:0] b_nx
);
    // Larger operand loses the smaller; equal operands are left alone.
    always_comb begin
        a_nx = a;
        b_nx = b;
        if (lt) begin
            b_nx = b - a;
        end else if (gt) begin
            a_nx = a - b;
        end
    end
endmodule

// File: rtl/frac_cast_step.sv
module frac_cast_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] divisor,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] rem_nx,
    output logic [W-1:0] cnt_nx,
    output logic         empty
);
    always_comb begin
        empty  = (rem == '0);
        rem_nx = rem - divisor;
        cnt_nx = cnt + {{(W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/frac_reduce.sv
module frac_reduce
    import frac_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] num_o,
    output logic [W-1:0] den_o,
    output logic [W-1:0] gcd_o,
    output logic         done_o,
    output logic         err_o
);
    localparam logic [W-1:0] ZERO = '0;

    typedef struct packed {
        frac_state_e  st;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] orig_n;
        logic [W-1:0] orig_d;
        logic [W-1:0] rem;
        logic [W-1:0] cnt;
        logic [W-1:0] g;
        logic [W-1:0] num;
        logic [W-1:0] den;
        logic         err;
    } regs_t;

    regs_t r_d, r_q;

    logic         c_lt, c_eq, c_gt;
    logic [W-1:0] a_nx, b_nx;
    logic [W-1:0] rem_nx, cnt_nx;
    logic         rem_empty;
    logic         busy;

    frac_cmp3 #(.W(W)) u_cmp (
        .a  (r_q.a),
        .b  (r_q.b),
        .lt (c_lt),
        .eq (c_eq),
        .gt (c_gt)
    );

    frac_euclid_step #(.W(W)) u_step (
        .a    (r_q.a),
        .b    (r_q.b),
        .lt   (c_lt),
        .gt   (c_gt),
        .a_nx (a_nx),
        .b_nx (b_nx)
    );

    frac_cast_step #(.W(W)) u_cast (
        .rem     (r_q.rem),
        .divisor (r_q.g),
        .cnt     (r_q.cnt),
        .rem_nx  (rem_nx),
        .cnt_nx  (cnt_nx),
        .empty   (rem_empty)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.orig_n = num_i;
                    r_d.orig_d = den_i;
                    if (num_i == ZERO || den_i == ZERO) begin
                        r_d.num = num_i;
                        r_d.den = den_i;
                        r_d.g   = ZERO;
                        r_d.err = 1'b1;
                        r_d.st  = ST_DONE;
                    end else begin
                        r_d.a   = num_i;
                        r_d.b   = den_i;
                        r_d.err = 1'b0;
                        r_d.st  = ST_GCD;
                    end
                end
            end
            ST_GCD: begin
                if (c_eq) begin
                    r_d.g   = r_q.a;
                    r_d.rem = r_q.orig_n;
                    r_d.cnt = ZERO;
                    r_d.st  = ST_CNUM;
                end else begin
                    r_d.a = a_nx;
                    r_d.b = b_nx;
                end
            end
            ST_CNUM: begin
                if (rem_empty) begin
                    r_d.num = r_q.cnt;
                    r_d.rem = r_q.orig_d;
                    r_d.cnt = ZERO;
                    r_d.st  = ST_CDEN;
                end else begin
                    r_d.rem = rem_nx;
                    r_d.cnt = cnt_nx;
                end
            end
            ST_CDEN: begin
                if (rem_empty) begin
                    r_d.den = r_q.cnt;
                    r_d.st  = ST_DONE;
                end else begin
                    r_d.rem = rem_nx;
                    r_d.cnt = cnt_nx;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, err: 1'b0, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy   = (r_q.st != ST_IDLE);
    assign done_o = (r_q.st == ST_DONE);
    assign err_o  = done_o & r_q.err;
    assign num_o  = r_q.num;
    assign den_o  = r_q.den;
    assign gcd_o  = r_q.g;

endmodule

// File: rtl/frac_reduce_chk.sv
module frac_reduce_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic [W-1:0] num_i,
    input logic [W-1:0] den_i,
    input logic [W-1:0] num_o,
    input logic [W-1:0] den_o,
    input logic [W-1:0] gcd_o,
    input logic         done_o,
    input logic         err_o
);
    logic [2*W-1:0] cap_n, cap_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_n <= '0;
            cap_d <= '0;
        end else if (!busy && start) begin
            cap_n <= (2*W)'(num_i);
            cap_d <= (2*W)'(den_i);
        end
    end

    AST_ZERO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (num_i == '0 || den_i == '0)) |=> (done_o && err_o)); // R4

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5

    AST_GCD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (gcd_o != '0)); // R2

    AST_CAST_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |->
            (((2*W)'(num_o) * (2*W)'(gcd_o)) == cap_n &&
             ((2*W)'(den_o) * (2*W)'(gcd_o)) == cap_d)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(num_o) && $stable(den_o) && $stable(gcd_o))); // R8

endmodule

bind frac_reduce frac_reduce_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .num_i  (num_i),
    .den_i  (den_i),
    .num_o  (num_o),
    .den_o  (den_o),
    .gcd_o  (gcd_o),
    .done_o (done_o),
    .err_o  (err_o)
);

// File: tb/frac_reduce_bench.sv
`timescale 1ns/1ps
module frac_reduce_bench;

    localparam int W  = 16;
    localparam int W8 = 8;
    localparam int NV = 10;
    localparam int LAT_LIMIT = 150000;

    localparam logic [31:0] VEC [NV] = '{
        {16'd3,     16'd12},
        {16'd12,    16'd18},
        {16'd7,     16'd13},
        {16'd9,     16'd9},
        {16'd65535, 16'd65535},
        {16'd1,     16'd1},
        {16'd100,   16'd75},
        {16'd4096,  16'd1},
        {16'd1,     16'd300},
        {16'd221,   16'd391}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic         start = 1'b0;
    logic [W-1:0] num_in = '0, den_in = '0;
    logic [W-1:0] num_out, den_out, gcd_out;
    logic         done, err;

    logic          start8 = 1'b0;
    logic [W8-1:0] num8 = '0, den8 = '0;
    logic [W8-1:0] num8_out, den8_out, gcd8_out;
    logic          done8, err8;

    frac_reduce #(.W(W)) u_frac_reduce (
        .clk(clk), .rst_n(rst_n), .start(start), .num_i(num_in), .den_i(den_in),
        .num_o(num_out), .den_o(den_out), .gcd_o(gcd_out), .done_o(done), .err_o(err)
    );

    frac_reduce #(.W(W8)) u_frac_reduce_w8 (
        .clk(clk), .rst_n(rst_n), .start(start8), .num_i(num8), .den_i(den8),
        .num_o(num8_out), .den_o(den8_out), .gcd_o(gcd8_out), .done_o(done8), .err_o(err8)
    );

    int total = 0;
    int fails = 0;
    int cyc   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_gcd(input int a, input int b);
        while (a != b) begin
            if (a < b) b = b - a;
            else       a = a - b;
        end
        return a;
    endfunction

    function automatic int ref_steps(input int a, input int b);
        int s = 0;
        while (a != b) begin
            if (a < b) b = b - a;
            else       a = a - b;
            s++;
        end
        return s;
    endfunction

    int lat;
    logic [W-1:0] r_num, r_den, r_gcd;
    logic         r_err;
    logic         r_after;

    // Launches one reduction on the wide instance; optional mid-run start with other operands.
    task automatic run16(input int n, input int d, input bit poke);
        @(negedge clk);
        num_in = W'(n); den_in = W'(d); start = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < LAT_LIMIT) begin
            if (poke && lat == 3) begin
                num_in = '0; den_in = 16'd5; start = 1'b1;
            end
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = 1'b0;
        end
        r_num = num_out; r_den = den_out; r_gcd = gcd_out; r_err = err;
        @(posedge clk);
        @(negedge clk);
        r_after = done;
    endtask

    task automatic check_nonzero(input int n, input int d, input bit poke);
        int g, s;
        string rq;
        g = ref_gcd(n, d);
        s = ref_steps(n, d);
        rq = poke ? "R6" : "R3";
        run16(n, d, poke);
        check(r_gcd == W'(g), "R2", $sformatf("gcd of %0d/%0d", n, d), r_gcd, g);
        check(r_num == W'(n / g), rq, $sformatf("num of %0d/%0d", n, d), r_num, n / g);
        check(r_den == W'(d / g), rq, $sformatf("den of %0d/%0d", n, d), r_den, d / g);
        check(r_err == 1'b0, "R5", "err low on success", r_err, 0);
        check(r_after == 1'b0, "R5", "done pulse one cycle", r_after, 0);
        check(lat == s + n / g + d / g + 4, poke ? "R6" : "R7",
              $sformatf("latency of %0d/%0d", n, d), lat, s + n / g + d / g + 4);
    endtask

    task automatic check_zero(input int n, input int d);
        run16(n, d, 1'b0);
        check(lat == 1, "R4", "error latency", lat, 1);
        check(r_err == 1'b1, "R4", "err flagged", r_err, 1);
        check(r_num == W'(n), "R4", "num passthrough", r_num, n);
        check(r_den == W'(d), "R4", "den passthrough", r_den, d);
        check(r_gcd == '0, "R4", "gcd zero on error", r_gcd, 0);
        check(r_after == 1'b0, "R5", "error done pulse one cycle", r_after, 0);
    endtask

    task automatic run8(input int n, input int d);
        int g, s, l;
        g = ref_gcd(n, d);
        s = ref_steps(n, d);
        @(negedge clk);
        num8 = W8'(n); den8 = W8'(d); start8 = 1'b1;
        @(posedge clk);
        l = 1;
        @(negedge clk);
        start8 = 1'b0;
        while (!done8 && l < LAT_LIMIT) begin
            @(posedge clk);
            l++;
            @(negedge clk);
        end
        check(num8_out == W8'(n / g), "R3", $sformatf("w8 num of %0d/%0d", n, d), num8_out, n / g);
        check(den8_out == W8'(d / g), "R3", $sformatf("w8 den of %0d/%0d", n, d), den8_out, d / g);
        check(gcd8_out == W8'(g), "R2", "w8 gcd", gcd8_out, g);
        check(l == s + n / g + d / g + 4, "R7", "w8 latency", l, s + n / g + d / g + 4);
    endtask

    initial begin
        wait (cyc >= 190000);
        total++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done == 1'b0 && err == 1'b0, "R1", "flags in reset", {done, err}, 0);
        check(num_out == '0 && den_out == '0 && gcd_out == '0, "R1", "outputs in reset",
              num_out | den_out | gcd_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && num_out == '0, "R1", "after reset release", done, 0);

        for (int i = 0; i < NV; i++) begin
            check_nonzero(int'(VEC[i][31:16]), int'(VEC[i][15:0]), 1'b0);
        end

        for (int i = 0; i < 20; i++) begin
            check_nonzero(int'($urandom_range(1, 1023)), int'($urandom_range(1, 1023)), 1'b0);
        end

        // R6: start with zero operands during a run must not disturb it
        check_nonzero(12, 18, 1'b1);

        check_zero(0, 7);
        check_zero(9, 0);
        check_zero(0, 0);

        // R8: outputs hold while idle
        check_nonzero(100, 75, 1'b0);
        num_in = 16'd1; den_in = 16'd2;
        repeat (6) @(negedge clk);
        check(num_out == 16'd4 && den_out == 16'd3 && gcd_out == 16'd25, "R8",
              "hold while idle", {num_out, den_out}, {16'd4, 16'd3});

        run8(255, 1);
        run8(255, 255);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule